// File: doc/BRIEF.md
# Buffered Output-Compare Timer Channel

This block is a 16-bit up-counter with one output-compare channel. The counter's clock comes from a selectable source: off, the module clock, or an external clock input that is synchronised and edge-detected. That source then passes through a power-of-two prescaler. Software writes a compare value over a small register interface. The value never drives the comparator directly. It lands in a holding buffer, and the active compare register picks it up only when the counter advances. When the counter is stopped, the pickup happens at once.

Each time the counter steps onto the active compare value, the channel raises a sticky match flag and updates its output pin. The pin action is chosen by two channel bits: keep, toggle, drive low or drive high. Software clears the flag by writing a zero to it. Buffered writes are never dropped. A single write is always applied at the next counter step, however slow the prescaled clock is. A second write before that step simply replaces the first.

Top module: `ocmp_timer`

## Requirements
- R1: After reset, all four registers read 0 and `ch_out` is 0.
- R2: A write to address 3 (compare value) stores the data in the holding buffer, and a read of address 3 returns the last value written.
- R3: While the counter is running, the active compare value changes only on a counter step. A second buffer write before that step replaces the first, and the first value never produces a match.
- R4: A single buffer write is taken into the active register at the next counter step, with any source or prescale. A match on that value is never lost.
- R5: Address 0 bits [2:0] hold prescale P. The counter steps once every 2^P source ticks. Any write to address 1 clears both the counter and the prescaler, so exactly M module-clock cycles after that write the counter reads floor(M / 2^P).
- R6: Address 0 bits [4:3] select the tick source, with these codes:
  - 0 stops the counter, so its value holds.
  - 1 and 2 tick on every module clock.
  - 3 ticks once per rising edge of `ext_clk`, seen after a two-stage synchroniser. Its high and low phases must each last at least two module-clock cycles.
- R7: Address 2 holds the channel control:
  - bit 7 is the match flag;
  - bit 4 enables the channel;
  - bits [3:2] choose the pin action on a match: 01 toggle, 10 low, 11 high, 00 none.
  
  When an enabled channel's counter steps to a value equal to the active compare value, the flag reads 1 one cycle later and `ch_out` takes the chosen action in the same cycle.
- R8: Writing address 2 with bit 7 = 0 clears the flag, and writing bit 7 = 1 leaves it unchanged. A match in the same cycle wins over the clear.
- R9: The counter wraps from 0xFFFF to 0, and a compare value of 0 matches on the wrap.
- R10: With bit 4 of address 2 at 0, a counter step onto the compare value sets no flag and leaves `ch_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External tick clock, asynchronous to `clk` |
| bus_addr | input | 2 | Register select: 0 control, 1 counter, 2 channel control, 3 compare value |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ch_out | output | 1 | Channel output pin |

## Verification
The bound checker watches several rules on every cycle:
- the buffer loads exactly what the bus wrote;
- the active compare value holds between counter steps and takes the buffer on each step;
- a stopped counter holds, and the counter wraps correctly;
- every internal match event produces the flag and the pin action one cycle later;
- a disabled channel stays silent.

Only the bench scenarios can show the counted behaviours. These are the exact step rate for a given prescale, counting of external edges through the synchroniser, and a value written twice inside one slow prescale period matching only on the second value. They also include a single write under the external clock taking effect after a fixed number of edges.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  typedef enum logic [1:0] {
    SRC_OFF     = 2'd0,
    SRC_SYS     = 2'd1,
    SRC_SYS_ALT = 2'd2,
    SRC_EXT     = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_HIGH   = 2'd3
  } pin_act_e;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_CHCTL = 2'd2;
  localparam logic [1:0] A_VALUE = 2'd3;

  // Last prescaler count before a counter step: 2^ps - 1
  function automatic int unsigned div_last(input int unsigned ps);
    return (32'd1 << ps) - 32'd1;
  endfunction

  // Pin level after a match, for a given action
  function automatic logic pin_after(input pin_act_e act, input logic cur);
    case (act)
      ACT_TOGGLE: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/ocmp_prescale.sv
module ocmp_prescale
  import ocmp_pkg::*;
#(
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_clk,
  input  clk_src_e        src,
  input  logic [PS_W-1:0] ps,
  input  logic            clr,
  output logic            adv
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_rise;
  logic                 tick;
  logic [DIV_W-1:0]     pcnt_q;
  logic [DIV_W-1:0]     lim;
  logic                 at_lim;

  // Synchroniser stages plus one extra flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_comb begin
    case (src)
      SRC_OFF: tick = 1'b0;
      SRC_EXT: tick = ext_rise;
      default: tick = 1'b1;
    endcase
  end

  assign lim    = DIV_W'(div_last(32'(ps)));
  assign at_lim = (pcnt_q >= lim);
  assign adv    = tick && !clr && at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt_q <= '0;
    else if (clr)  pcnt_q <= '0;
    else if (tick) pcnt_q <= at_lim ? '0 : pcnt_q + DIV_W'(1);
  end

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stopped,
  input  logic             adv,
  input  logic [CNT_W-1:0] cnt,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  input  logic             ctl_wr,
  input  logic             ctl_flag_keep,
  input  logic [2:0]       ctl_mode,
  output logic [CNT_W-1:0] buf_q,
  output logic [CNT_W-1:0] active_q,
  output logic             flag_q,
  output logic [2:0]       mode_q,
  output logic             pin_q,
  output logic             match_evt
);
  logic adv_q;

  // Holding buffer: every bus write lands here
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (val_wr) buf_q <= val_wdata;
  end

  // Active register: follows buffer when stopped, else on counter steps
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              active_q <= '0;
    else if (stopped || adv) active_q <= buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adv_q <= 1'b0;
    else        adv_q <= adv;
  end

  // Compare only right after a step, against the freshly loaded value
  assign match_evt = adv_q && mode_q[2] && (cnt == active_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         flag_q <= 1'b0;
    else if (match_evt)                 flag_q <= 1'b1;
    else if (ctl_wr && !ctl_flag_keep)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= '0;
    else if (ctl_wr) mode_q <= ctl_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pin_q <= 1'b0;
    else if (match_evt) pin_q <= pin_after(pin_act_e'(mode_q[1:0]), pin_q);
  end

endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
  import ocmp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             ch_out
);
  localparam int SRC_LSB = PS_W;

  logic             wr_ctrl, wr_cnt, wr_chctl, wr_val;
  clk_src_e         src_q;
  logic [PS_W-1:0]  ps_q;
  logic [CNT_W-1:0] cnt_q;
  logic             adv;
  logic [CNT_W-1:0] buf_q, active_q;
  logic             flag_q, match_evt;
  logic [2:0]       mode_q;

  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_cnt   = bus_wr && (bus_addr == A_COUNT);
  assign wr_chctl = bus_wr && (bus_addr == A_CHCTL);
  assign wr_val   = bus_wr && (bus_addr == A_VALUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_OFF;
      ps_q  <= '0;
    end else if (wr_ctrl) begin
      src_q <= clk_src_e'(bus_wdata[SRC_LSB+1:SRC_LSB]);
      ps_q  <= bus_wdata[PS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= '0;
    else if (adv)    cnt_q <= cnt_q + CNT_W'(1);
  end

  ocmp_prescale #(.PS_W(PS_W), .SYNC_STAGES(SYNC_STAGES)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_clk (ext_clk),
    .src     (src_q),
    .ps      (ps_q),
    .clr     (wr_cnt),
    .adv     (adv)
  );

  ocmp_channel #(.CNT_W(CNT_W)) u_ch (
    .clk           (clk),
    .rst_n         (rst_n),
    .stopped       (src_q == SRC_OFF),
    .adv           (adv),
    .cnt           (cnt_q),
    .val_wr        (wr_val),
    .val_wdata     (bus_wdata),
    .ctl_wr        (wr_chctl),
    .ctl_flag_keep (bus_wdata[7]),
    .ctl_mode      (bus_wdata[4:2]),
    .buf_q         (buf_q),
    .active_q      (active_q),
    .flag_q        (flag_q),
    .mode_q        (mode_q),
    .pin_q         (ch_out),
    .match_evt     (match_evt)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = CNT_W'({src_q, ps_q});
      A_COUNT: bus_rdata = cnt_q;
      A_CHCTL: bus_rdata = CNT_W'({flag_q, 2'b00, mode_q, 2'b00});
      default: bus_rdata = buf_q;
    endcase
  end

endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [1:0]       src,
  input logic             adv,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] buf_q,
  input logic [CNT_W-1:0] active_q,
  input logic             flag_q,
  input logic [2:0]       mode_q,
  input logic             match_evt,
  input logic             ch_out
);

  p_buf_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=> (buf_q == $past(bus_wdata)));

  p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src != 2'd0 && !adv) |=> $stable(active_q));

  p_active_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (active_q == $past(buf_q)));

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd0 && !(bus_wr && bus_addr == 2'd1)) |=> $stable(cnt));

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_q);

  p_pin_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode_q[1:0] == 2'b11) |=> ch_out);

  p_pin_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode_q[1:0] == 2'b10) |=> !ch_out);

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !bus_wdata[7] && !match_evt) |=> !flag_q);

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt == {CNT_W{1'b1}}) |=> (cnt == '0));

  p_quiet_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[2] |=> $stable(ch_out));

  p_quiet_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[2] && !flag_q) |=> !flag_q);

endmodule

bind ocmp_timer ocmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .src       (src_q),
  .adv       (adv),
  .cnt       (cnt_q),
  .buf_q     (buf_q),
  .active_q  (active_q),
  .flag_q    (flag_q),
  .mode_q    (mode_q),
  .match_evt (match_evt),
  .ch_out    (ch_out)
);

// File: tb/sim_ocmp_timer.sv
`timescale 1ns/100ps
module sim_ocmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        ch_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [15:0] exp;
    bit          is_pin;
    string       tag;
  } item_t;

  item_t q[$];
  event  chk_ev;

  ocmp_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_clk   (ext_clk),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ch_out    (ch_out)
  );

  always #2.5 clk = ~clk;

  // Monitor: pops expected items and compares them with the outputs
  initial begin : monitor
    forever begin
      @(chk_ev);
      #0.2;
      while (q.size() > 0) begin
        item_t       it;
        logic [15:0] act;
        it  = q.pop_front();
        act = it.is_pin ? {15'd0, ch_out} : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [15:0] e, input string tag);
    bus_addr = a;
    q.push_back('{e, 1'b0, tag});
    -> chk_ev;
    #0.5;
  endtask

  task automatic expect_pin(input logic e, input string tag);
    q.push_back('{{15'd0, e}, 1'b1, tag});
    -> chk_ev;
    #0.5;
  endtask

  task automatic ext_pulses(input int n);
    repeat (n) begin
      ext_clk = 1'b1;
      step(4);
      ext_clk = 1'b0;
      step(4);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    expect_reg(2'd0, 16'h0000, "R1 ctrl");
    expect_reg(2'd1, 16'h0000, "R1 count");
    expect_reg(2'd2, 16'h0000, "R1 chctl");
    step(1);
    expect_reg(2'd3, 16'h0000, "R1 value");
    expect_pin(1'b0, "R1 pin");
    step(1);

    // R5 prescale 8 on module clock
    wr(2'd0, 16'h000B);
    wr(2'd1, 16'h0000);
    step(20);
    expect_reg(2'd1, 16'd2, "R5 count after 20");
    step(4);
    expect_reg(2'd1, 16'd3, "R5 count after 24");
    expect_reg(2'd0, 16'h000B, "R5 ctrl readback");

    // R6 stopped source holds the counter
    wr(2'd0, 16'h0003);
    step(50);
    expect_reg(2'd1, 16'd3, "R6 stopped hold");

    // R6 alternate internal source, prescale 1
    wr(2'd0, 16'h0010);
    wr(2'd1, 16'h0000);
    step(9);
    expect_reg(2'd1, 16'd9, "R6 source 2 count");

    // R6 external edges
    wr(2'd0, 16'h0018);
    wr(2'd1, 16'h0000);
    ext_pulses(5);
    step(4);
    expect_reg(2'd1, 16'd5, "R6 external edges");

    // R7 set-high action, R2 readback
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h001C);
    wr(2'd3, 16'd7);
    expect_reg(2'd3, 16'd7, "R2 value readback");
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'h0000);
    step(7);
    expect_reg(2'd1, 16'd7, "R7 count at compare");
    expect_reg(2'd2, 16'h001C, "R7 flag not yet");
    expect_pin(1'b0, "R7 pin not yet");
    step(1);
    expect_reg(2'd2, 16'h009C, "R7 flag set");
    expect_pin(1'b1, "R7 pin high");

    // R8 flag write semantics
    step(1);
    wr(2'd2, 16'h009C);
    expect_reg(2'd2, 16'h009C, "R8 write one keeps flag");
    wr(2'd2, 16'h001C);
    expect_reg(2'd2, 16'h001C, "R8 write zero clears");

    // R3 replacement within a slow prescale period, drive-low action
    wr(2'd0, 16'h000F);
    wr(2'd2, 16'h0018);
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'd1);
    wr(2'd3, 16'd2);
    expect_reg(2'd3, 16'd2, "R3 buffer replaced");
    step(128);
    expect_reg(2'd1, 16'd1, "R3 count at first value");
    expect_reg(2'd2, 16'h0018, "R3 first value no match");
    step(127);
    expect_reg(2'd2, 16'h0098, "R4 replaced value matches");
    expect_pin(1'b0, "R7 pin low");

    // R4 single write under external clock, toggle action
    wr(2'd0, 16'h0018);
    wr(2'd2, 16'h0014);
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'd3);
    expect_reg(2'd3, 16'd3, "R2 value readback ext");
    ext_pulses(2);
    step(4);
    expect_reg(2'd1, 16'd2, "R4 count before match");
    expect_reg(2'd2, 16'h0014, "R4 no flag yet");
    ext_pulses(1);
    step(4);
    expect_reg(2'd2, 16'h0094, "R4 single write matched");
    expect_pin(1'b1, "R4 pin toggled");

    // R10 disabled channel: drive-low action must not act
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0008);
    wr(2'd3, 16'd4);
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'h0000);
    step(10);
    expect_reg(2'd2, 16'h0008, "R10 no flag");
    expect_pin(1'b1, "R10 pin unchanged");

    // R9 wrap and compare on zero
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0018);
    wr(2'd3, 16'd0);
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'h0000);
    step(65535);
    expect_reg(2'd1, 16'hFFFF, "R9 count top");
    expect_reg(2'd2, 16'h0018, "R9 no flag before wrap");
    step(1);
    expect_reg(2'd1, 16'h0000, "R9 wrapped");
    step(1);
    expect_reg(2'd2, 16'h0098, "R9 match on zero");
    expect_pin(1'b0, "R9 pin low");

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule